// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block handles the address phase of an I2C slave. It brings SCL and SDA into the clock domain, finds START and STOP conditions, and shifts in the first byte after a START. It then decides whether to pull SDA low in the acknowledge slot. A host configures it through a small register write port, which holds the own 7-bit address, a general-call enable, a software-recognition mode bit and a NACK bit. The host learns what happened by reading match, general-call, read/write and byte-ready flags, and it is signalled by a level interrupt.

In hardware mode the block answers by itself. It acknowledges its own address and the general-call address, and it never acknowledges the START byte. In software mode every address byte is handed to the host. The block stretches SCL low until the host writes the control register, and the NACK bit in that write decides the acknowledge slot. Open-drain behaviour is left to the pads: the `*_oe_o` outputs mean "pull the line low".

Top module: `i2c_addr_recog`

## Requirements
- R1: After a synchronous reset, scl_oe_o, sda_oe_o, match_o, gcall_o, rdwr_o, rx_ready_o and irq_o are all 0.
- R2: In hardware mode (sw_mode 0), a byte whose upper seven bits equal the own address sets match_o to 1 and gcall_o to 0, and copies bit 0 of the byte (the R/W bit, 1 = read) into rdwr_o. The acknowledge slot is pulled low when the NACK bit is 0 and left released when it is 1.
- R3: In hardware mode with gc_en 1, the byte 0x00 (general call) sets match_o and gcall_o to 1 and rdwr_o to 0. The acknowledge slot follows the NACK bit.
- R4: In hardware mode with gc_en 1, the byte 0x01 (START byte) sets match_o and gcall_o to 1 and rdwr_o to 1. SDA is never pulled low in its acknowledge slot, whatever the NACK bit holds.
- R5: In hardware mode, an address that is neither the own address nor an enabled general call or START byte leaves SDA released and leaves match_o, gcall_o and rx_ready_o unchanged. With gc_en 0, the byte 0x00 counts as non-matching.
- R6: In software mode (sw_mode 1), every address byte sets rx_ready_o, presents the byte on rx_byte_o and updates rdwr_o from its bit 0. match_o and gcall_o stay 0.
- R7: In software mode, SCL is held low from the falling SCL edge after the eighth bit until the host writes the control register. The acknowledge slot is then pulled low if the written NACK bit is 0, and SCL is released.
- R8: irq_o is 1 exactly when match_o or rx_ready_o is 1.
- R9: A host status read (stat_rd_i) or a detected START clears match_o, gcall_o and rx_ready_o.
- R10: A repeated START in the middle of an address byte discards the partial byte and restarts reception with the next bit.
- R11: sda_oe_o is released at the falling SCL edge that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | 1 = pull SDA low (acknowledge) |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_own_addr_i | input | ADDR_W | Own slave address |
| ctl_gc_en_i | input | 1 | General-call / START-byte recognition enable |
| ctl_sw_mode_i | input | 1 | 1 = software decides the acknowledge |
| ctl_nack_i | input | 1 | 1 = answer NACK |
| stat_rd_i | input | 1 | Status read strobe, clears the flags |
| match_o | output | 1 | Address matched in hardware |
| gcall_o | output | 1 | General call or START byte seen |
| rdwr_o | output | 1 | R/W bit of the last address byte |
| rx_ready_o | output | 1 | Byte ready for the host (software mode) |
| rx_byte_o | output | ADDR_W+1 | Last received address byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the stretched acknowledge. To get there, the bench's bus master must actually try to raise SCL while the slave still holds it. The master then has to wait on the wired-AND line level before it samples the acknowledge. The bench models the bus as open-drain, so the master's clock only rises after the host write. It checks that SCL stays low while the master releases it and that the acknowledge follows the NACK bit written during the stall. A repeated START is forced after three address bits to show that the partial byte is dropped.

// File: rtl/i2c_ar_pkg.sv
package i2c_ar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DECIDE,
    ST_HOLD,
    ST_ACK,
    ST_DONE
  } ar_state_e;

  typedef struct packed {
    logic is_sw;
    logic match;
    logic gcall;
    logic rw;
    logic ack;
  } ar_dec_t;

endpackage

// File: rtl/i2c_ar_sync.sv
module i2c_ar_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din[gi]};
      end
      assign dout[gi] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_ar_cond.sv
module i2c_ar_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = ~scl_d & scl_s;
  assign scl_fall = scl_d & ~scl_s;

endmodule

// File: rtl/i2c_ar_fsm.sv
module i2c_ar_fsm
  import i2c_ar_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              sw_mode,
  input  logic              nack,
  input  logic              host_wr,
  input  logic              host_nack,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              dec_valid,
  output ar_dec_t           dec,
  output logic [ADDR_W:0]   byte_o
);

  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  ar_state_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] shnext;
  logic [ADDR_W-1:0] addr_c;
  ar_dec_t           dec_c;

  assign shnext = {shreg[BYTE_W-2:0], sda_s};
  assign addr_c = shnext[BYTE_W-1:1];

  always_comb begin
    dec_c       = '0;
    dec_c.is_sw = sw_mode;
    dec_c.rw    = shnext[0];
    if (!sw_mode) begin
      if (gc_en && (addr_c == '0)) begin
        dec_c.match = 1'b1;
        dec_c.gcall = 1'b1;
        dec_c.ack   = ~shnext[0] & ~nack;
      end else if (addr_c == own_addr) begin
        dec_c.match = 1'b1;
        dec_c.ack   = ~nack;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      sda_oe    <= 1'b0;
      scl_oe    <= 1'b0;
      dec_valid <= 1'b0;
      dec       <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (start_p) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg <= shnext;
              if (cnt == CNT_W'(BYTE_W - 1)) begin
                st        <= ST_DECIDE;
                dec       <= dec_c;
                dec_valid <= 1'b1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          ST_DECIDE: begin
            if (scl_fall) begin
              if (dec.is_sw) begin
                scl_oe <= 1'b1;
                st     <= ST_HOLD;
              end else if (dec.ack) begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
              end else begin
                st <= ST_DONE;
              end
            end
          end
          ST_HOLD: begin
            if (host_wr) begin
              scl_oe <= 1'b0;
              sda_oe <= ~host_nack;
              st     <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign byte_o = shreg;

  // R7: the stretch and the acknowledge drive never overlap
  p_one_driver_r7: assert property (@(posedge clk) disable iff (rst)
    !(scl_oe && sda_oe));

  // R7: clock stretching only after a software-mode decision
  p_hold_sw_only_r7: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> dec.is_sw);

  // R11: acknowledge released at the end of its slot
  p_release_ack_r11: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && scl_fall && !start_p && !stop_p) |=> !sda_oe);

  // R4: a START byte decision never acknowledges
  p_no_ack_startbyte_r4: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec.gcall && dec.rw) |-> !dec.ack);

endmodule

// File: rtl/i2c_addr_recog.sv
module i2c_addr_recog
  import i2c_ar_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              ctl_we_i,
  input  logic [ADDR_W-1:0] ctl_own_addr_i,
  input  logic              ctl_gc_en_i,
  input  logic              ctl_sw_mode_i,
  input  logic              ctl_nack_i,
  input  logic              stat_rd_i,
  output logic              match_o,
  output logic              gcall_o,
  output logic              rdwr_o,
  output logic              rx_ready_o,
  output logic [ADDR_W:0]   rx_byte_o,
  output logic              irq_o
);

  logic [1:0]        bus_s;
  logic              scl_s, sda_s;
  logic              start_p, stop_p, scl_rise, scl_fall;
  logic [ADDR_W-1:0] own_q;
  logic              gcen_q, sw_q, nack_q;
  logic              dec_valid;
  ar_dec_t           dec;
  logic [ADDR_W:0]   fsm_byte;
  logic              match_n, gcall_n, rdy_n;

  i2c_ar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2c_ar_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q  <= '0;
      gcen_q <= 1'b0;
      sw_q   <= 1'b0;
      nack_q <= 1'b0;
    end else if (ctl_we_i) begin
      own_q  <= ctl_own_addr_i;
      gcen_q <= ctl_gc_en_i;
      sw_q   <= ctl_sw_mode_i;
      nack_q <= ctl_nack_i;
    end
  end

  i2c_ar_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .own_addr (own_q),
    .gc_en    (gcen_q),
    .sw_mode  (sw_q),
    .nack     (nack_q),
    .host_wr  (ctl_we_i),
    .host_nack(ctl_nack_i),
    .sda_oe   (sda_oe_o),
    .scl_oe   (scl_oe_o),
    .dec_valid(dec_valid),
    .dec      (dec),
    .byte_o   (fsm_byte)
  );

  // set wins over clear; the two never share a cycle on a legal bus
  always_comb begin
    match_n = match_o;
    gcall_n = gcall_o;
    rdy_n   = rx_ready_o;
    if (stat_rd_i || start_p) begin
      match_n = 1'b0;
      gcall_n = 1'b0;
      rdy_n   = 1'b0;
    end
    if (dec_valid) begin
      if (dec.is_sw) begin
        rdy_n = 1'b1;
      end else if (dec.match) begin
        match_n = 1'b1;
        gcall_n = dec.gcall;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_o    <= 1'b0;
      gcall_o    <= 1'b0;
      rx_ready_o <= 1'b0;
      rdwr_o     <= 1'b0;
      rx_byte_o  <= '0;
      irq_o      <= 1'b0;
    end else begin
      match_o    <= match_n;
      gcall_o    <= gcall_n;
      rx_ready_o <= rdy_n;
      irq_o      <= match_n | rdy_n;
      if (dec_valid && (dec.is_sw || dec.match)) rdwr_o <= dec.rw;
      if (dec_valid && dec.is_sw) rx_byte_o <= fsm_byte;
    end
  end

  // R8: interrupt level tracks the flags
  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (match_o | rx_ready_o));

  // R3: general-call flag never without a match
  p_gcall_has_match_r3: assert property (@(posedge clk) disable iff (rst)
    gcall_o |-> match_o);

  // R9: a START leaves the flags clear
  p_start_clears_r9: assert property (@(posedge clk) disable iff (rst)
    start_p |=> (!match_o && !gcall_o && !rx_ready_o));

  // R6: software mode never reports a hardware match
  p_sw_no_match_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec.is_sw) |=> (!$rose(match_o) && rx_ready_o));

endmodule

// File: tb/i2c_addr_recog_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_recog_tb_top;

  localparam int AW = 7;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  wire  scl_bus = scl_m & ~scl_oe;
  wire  sda_bus = sda_m & ~sda_oe;

  logic          ctl_we = 1'b0;
  logic [AW-1:0] c_own = '0;
  logic          c_gc = 1'b0, c_sw = 1'b0, c_nack = 1'b0;
  logic          stat_rd = 1'b0;
  logic          match, gcall, rdwr, rdy, irq;
  logic [AW:0]   rx_byte;

  i2c_addr_recog #(.ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
    .ctl_we_i(ctl_we), .ctl_own_addr_i(c_own), .ctl_gc_en_i(c_gc),
    .ctl_sw_mode_i(c_sw), .ctl_nack_i(c_nack), .stat_rd_i(stat_rd),
    .match_o(match), .gcall_o(gcall), .rdwr_o(rdwr), .rx_ready_o(rdy),
    .rx_byte_o(rx_byte), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  int e_match = 0, e_gc = 0, e_rw = 0, e_rdy = 0, e_ack = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference flags compared on every clock while the bus is quiet
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk(match, e_match, "R2/R3 match");
      chk(gcall, e_gc, "R3/R4 gcall");
      chk(rdwr, e_rw, "R2/R6 rdwr");
      chk(rdy, e_rdy, "R6 rx_ready");
      chk(irq, (e_match | e_rdy), "R8 irq");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int own, input int gc, input int sw, input int nk);
    c_own = AW'(own); c_gc = gc[0]; c_sw = sw[0]; c_nack = nk[0];
    ctl_we = 1'b1; tick(1); ctl_we = 1'b0; tick(1);
  endtask

  task automatic host_read();
    cmp_en = 1'b0;
    stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    e_match = 0; e_gc = 0; e_rdy = 0;
    tick(1); cmp_en = 1'b1;
  endtask

  task automatic start_c();
    sda_m = 1'b1; tick(H); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; tick(H); scl_m = 1'b1; tick(H); sda_m = 1'b1; tick(H);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; tick(H); scl_m = 1'b1; tick(H); scl_m = 1'b0; tick(H);
  endtask

  task automatic ack_slot(output int ackbit);
    sda_m = 1'b1; tick(H); scl_m = 1'b1;
    while (scl_bus !== 1'b1) tick(1);
    tick(H/2); ackbit = (sda_bus === 1'b0) ? 1 : 0;
    tick(H/2); scl_m = 1'b0;
  endtask

  // behavioural expectation for one address byte
  task automatic model(input int b, input int hnack);
    int a, rw;
    a = (b >> 1) & 8'h7f; rw = b & 1;
    e_match = 0; e_gc = 0; e_rdy = 0; e_ack = 0;
    if (c_sw) begin
      e_rdy = 1; e_rw = rw; e_ack = !hnack;
    end else if (c_gc && a == 0) begin
      e_match = 1; e_gc = 1; e_rw = rw; e_ack = (rw == 0) && !c_nack;
    end else if (a == int'(c_own)) begin
      e_match = 1; e_rw = rw; e_ack = !c_nack;
    end
  endtask

  task automatic xact(input int b, input int hnack, input string tag);
    int got;
    cmp_en = 1'b0;
    start_c();
    e_match = 0; e_gc = 0; e_rdy = 0;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    model(b, hnack);
    if (c_sw) begin
      tick(4);
      cmp_en = 1'b1;
      chk(scl_oe, 1, {tag, " R7 scl held"});
      chk(sda_oe, 0, {tag, " R7 no ack before host"});
      chk(rx_byte, b, {tag, " R6 rx_byte"});
      scl_m = 1'b1; tick(12);
      chk(scl_bus, 0, {tag, " R7 bus scl stays low"});
      scl_m = 1'b0;
      c_nack = hnack[0]; ctl_we = 1'b1; tick(1); ctl_we = 1'b0;
      tick(4);
      chk(scl_oe, 0, {tag, " R7 scl released"});
    end
    ack_slot(got);
    chk(got, e_ack, {tag, " ack slot"});
    tick(H);
    chk(sda_oe, 0, {tag, " R11 sda released"});
    cmp_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5); rst = 1'b0; tick(3);
    chk(scl_oe, 0, "R1 scl_oe"); chk(sda_oe, 0, "R1 sda_oe");
    chk(match, 0, "R1 match");   chk(gcall, 0, "R1 gcall");
    chk(rdwr, 0, "R1 rdwr");     chk(rdy, 0, "R1 rx_ready");
    chk(irq, 0, "R1 irq");
    cmp_en = 1'b1;

    cfg(7'h52, 1, 0, 0);
    xact(8'hA4, 0, "R2 own write ack"); stop_c(); host_read();
    chk(irq, 0, "R9 read clears irq");
    cfg(7'h52, 1, 0, 1);
    xact(8'hA5, 0, "R2 own read nack"); stop_c(); host_read();
    cfg(7'h52, 1, 0, 0);
    xact(8'h80, 0, "R5 foreign addr"); stop_c();
    xact(8'h00, 0, "R3 gcall ack"); stop_c();
    cmp_en = 1'b0; start_c();
    e_match = 0; e_gc = 0; e_rdy = 0;
    chk(match, 0, "R9 start clears match"); chk(irq, 0, "R9 start clears irq");
    stop_c(); cmp_en = 1'b1;
    cfg(7'h52, 1, 0, 1);
    xact(8'h00, 0, "R3 gcall nack"); stop_c(); host_read();
    cfg(7'h52, 1, 0, 0);
    xact(8'h01, 0, "R4 start byte"); stop_c(); host_read();
    cfg(7'h52, 0, 0, 0);
    xact(8'h00, 0, "R5 gcall disabled"); stop_c();
    cfg(7'h52, 1, 0, 0);
    cmp_en = 1'b0; start_c();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    xact(8'hA4, 0, "R10 repeated start"); stop_c(); host_read();
    cfg(7'h52, 1, 1, 0);
    xact(8'h00, 0, "R6 sw gcall byte"); stop_c(); host_read();
    xact(8'hA5, 1, "R7 sw nack"); stop_c(); host_read();
    cfg(7'h52, 1, 1, 0);
    xact(8'h33, 0, "R6 sw foreign byte acked"); stop_c(); host_read();

    tick(4);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule